// File: doc/BRIEF.md
# SPI Serial Byte Memory Slave

This block is the serial front end of a small byte-addressable memory, 2048 locations of eight bits by default. An external master selects it by pulling the active-low select low. It then clocks in a command byte, an optional two-byte address and data, most significant bit first. The block samples the serial input on rising clock edges and updates the serial output on falling edges. The output comes with a separate enable, so the pad can float whenever the slave is not returning data. This lets a master tie the data-in and data-out wires together.

The block keeps an eight-bit status word. Bit 0 always reads zero. Bit 1 is the write-enable latch. Bits 7 to 2 are configuration bits that a status write can change. Reads and writes stream through memory while select stays low, and the address steps by one after each byte. All serial inputs are resynchronised into the system clock domain, so the serial clock must be several times slower than the system clock.

Top module: `spiMemSlave`

## Requirements
- R1: Opcode, address and data bytes travel most significant bit first in both directions.
- R2: The first eight bits after select falls form the command. Command codes: 0x06 enables writes, 0x04 disables writes, 0x05 reads status, 0x01 writes status, 0x03 reads memory, 0x02 writes memory.
- R3: After any other command value, the block ignores the serial input until select falls again, and the output enable stays low.
- R4: Memory commands take a 16-bit address. Only the low 11 bits pick the location, and the upper five bits have no effect.
- R5: Each byte read or written moves the address up by one while select stays low, and 0x7FF is followed by 0x000.
- R6: A memory or status write changes nothing unless the write-enable latch was set when the byte completed.
- R7: The write-enable latch reads as status bit 1. Command 0x06 sets it and command 0x04 clears it. It clears when select rises after at least one byte of a write or status write was accepted.
- R8: Status bits 7..2 take the written byte's bits 7..2. Status bit 0 reads 0. Repeated status-read bytes return the same word.
- R9: A byte whose eighth bit has not been sampled before select rises is discarded. This includes a final clock rise that arrives together with the select rise.
- R10: The output enable is high only while a read or status read is returning data, and low after reset, during command and address bytes, during writes and while select is high.
- R11: The serial output holds steady while the serial clock is high.
- R12: Raising select at any point abandons the current command, and the next command starts cleanly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| csN | input | 1 | Active-low select |
| si | input | 1 | Serial data from the master |
| so | output | 1 | Serial data to the master |
| soOe | output | 1 | Output enable for the serial data pad |

## Verification
Two events can land in the same system-clock cycle: a select rise and the serial-clock rise that carries a byte's eighth bit. The bench provokes this by raising both lines on the same system-clock edge partway through a memory write. The write-enable latch has been set beforehand and the target location holds a known value. The result is judged only at the ports. The location must still hold its old value, and a later status read must still show bit 1 set, because no byte was accepted. The same bench also crosses the 0x7FF boundary in one burst and probes a locked-out frame for any output enable.

// File: rtl/spiMemPkg.sv
package spiMemPkg;

  localparam logic [7:0] OpWrEnable  = 8'h06;
  localparam logic [7:0] OpWrDisable = 8'h04;
  localparam logic [7:0] OpRdStatus  = 8'h05;
  localparam logic [7:0] OpWrStatus  = 8'h01;
  localparam logic [7:0] OpRdMem     = 8'h03;
  localparam logic [7:0] OpWrMem     = 8'h02;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPC,
    ST_AHI,
    ST_ALO,
    ST_RDAT,
    ST_WDAT,
    ST_RSTAT,
    ST_WSTAT,
    ST_LOCK,
    ST_SKIP
  } ctrlState_t;

  typedef struct packed {
    logic csStart;
    logic csEnd;
    logic setWel;
    logic clrWel;
    logic loadHi;
    logic loadLo;
    logic memWr;
    logic statWr;
    logic txLoadMem;
    logic txLoadStat;
    logic txShift;
  } strobe_t;

endpackage

// File: rtl/spiMemSync.sv
module spiMemSync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[0] <= RST_VAL;
        else       stg[0] <= dIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[i] <= RST_VAL;
        else       stg[i] <= stg[i-1];
      end
    end
  end

  assign dOut = stg[STAGES-1];

endmodule

// File: rtl/spiMemCtrl.sv
module spiMemCtrl
  import spiMemPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckS,
  input  logic       csS,
  input  logic       siS,
  output strobe_t    stb,
  output logic [7:0] rxByte,
  output ctrlState_t stateQ,
  output logic [2:0] bitCnt
);

  logic       sckPrev, csPrev;
  logic [6:0] rxSh;
  logic       pendLoad;
  logic       isReadQ;
  ctrlState_t nextState;

  logic sckRise, sckFall, csFall, csRise, byteDone, rdPhase;

  assign sckRise  = sckS & ~sckPrev & ~csS;
  assign sckFall  = ~sckS & sckPrev & ~csS;
  assign csFall   = ~csS & csPrev;
  assign csRise   = csS & ~csPrev;
  assign byteDone = sckRise && (bitCnt == 3'd7);
  assign rxByte   = {rxSh, siS};
  assign rdPhase  = (stateQ == ST_RDAT) || (stateQ == ST_RSTAT);

  always_comb begin
    nextState = stateQ;
    case (stateQ)
      ST_OPC: begin
        case (rxByte)
          OpRdMem, OpWrMem:         nextState = ST_AHI;
          OpRdStatus:               nextState = ST_RSTAT;
          OpWrStatus:               nextState = ST_WSTAT;
          OpWrEnable, OpWrDisable:  nextState = ST_SKIP;
          default:                  nextState = ST_LOCK;
        endcase
      end
      ST_AHI:   nextState = ST_ALO;
      ST_ALO:   nextState = isReadQ ? ST_RDAT : ST_WDAT;
      ST_WSTAT: nextState = ST_SKIP;
      default:  nextState = stateQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev  <= 1'b0;
      csPrev   <= 1'b1;
      rxSh     <= '0;
      bitCnt   <= '0;
      pendLoad <= 1'b0;
      isReadQ  <= 1'b0;
      stateQ   <= ST_IDLE;
    end else begin
      sckPrev <= sckS;
      csPrev  <= csS;
      if (csFall || csRise) begin
        bitCnt   <= '0;
        pendLoad <= 1'b0;
      end else begin
        if (sckRise) begin
          rxSh   <= {rxSh[5:0], siS};
          bitCnt <= 3'(bitCnt + 3'd1);
        end
        if (byteDone && ((nextState == ST_RDAT) || (nextState == ST_RSTAT)))
          pendLoad <= 1'b1;
        else if (sckFall)
          pendLoad <= 1'b0;
      end
      if (csRise)        stateQ <= ST_IDLE;
      else if (csFall)   stateQ <= ST_OPC;
      else if (byteDone) stateQ <= nextState;
      if (byteDone && stateQ == ST_OPC) isReadQ <= (rxByte == OpRdMem);
    end
  end

  always_comb begin
    stb            = '0;
    stb.csStart    = csFall;
    stb.csEnd      = csRise;
    stb.setWel     = byteDone && (stateQ == ST_OPC) && (rxByte == OpWrEnable);
    stb.clrWel     = byteDone && (stateQ == ST_OPC) && (rxByte == OpWrDisable);
    stb.loadHi     = byteDone && (stateQ == ST_AHI);
    stb.loadLo     = byteDone && (stateQ == ST_ALO);
    stb.memWr      = byteDone && (stateQ == ST_WDAT);
    stb.statWr     = byteDone && (stateQ == ST_WSTAT);
    stb.txLoadMem  = sckFall && pendLoad && (stateQ == ST_RDAT);
    stb.txLoadStat = sckFall && pendLoad && (stateQ == ST_RSTAT);
    stb.txShift    = sckFall && !pendLoad && rdPhase;
  end

endmodule

// File: rtl/spiMemData.sv
module spiMemData
  import spiMemPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        rxByte,
  output logic              so,
  output logic              soOe,
  output logic [ADDR_W-1:0] addrQ,
  output logic              welQ,
  output logic              commitSeen
);

  localparam int HI_W  = ADDR_W - 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]      mem [DEPTH];
  logic [HI_W-1:0] addrHiQ;
  logic [5:0]      cfgQ;
  logic [7:0]      txSh;
  logic [7:0]      statusW;

  assign statusW = {cfgQ, welQ, 1'b0};
  assign so      = txSh[7];

  always_ff @(posedge clk) begin
    if (stb.memWr && welQ) mem[addrQ] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHiQ    <= '0;
      addrQ      <= '0;
      cfgQ       <= '0;
      welQ       <= 1'b0;
      commitSeen <= 1'b0;
      txSh       <= '0;
      soOe       <= 1'b0;
    end else begin
      if (stb.csStart) begin
        commitSeen <= 1'b0;
        soOe       <= 1'b0;
      end else if (stb.csEnd) begin
        soOe       <= 1'b0;
        commitSeen <= 1'b0;
        if (commitSeen) welQ <= 1'b0;
      end else begin
        if (stb.setWel) welQ <= 1'b1;
        if (stb.clrWel) welQ <= 1'b0;
        if (stb.loadHi) addrHiQ <= rxByte[HI_W-1:0];
        if (stb.loadLo) begin
          addrQ <= {addrHiQ, rxByte};
        end else if (stb.memWr) begin
          addrQ <= addrQ + 1'b1;
          if (welQ) commitSeen <= 1'b1;
        end else if (stb.txLoadMem) begin
          txSh  <= mem[addrQ];
          addrQ <= addrQ + 1'b1;
          soOe  <= 1'b1;
        end
        if (stb.statWr && welQ) begin
          cfgQ       <= rxByte[7:2];
          commitSeen <= 1'b1;
        end
        if (stb.txLoadStat) begin
          txSh <= statusW;
          soOe <= 1'b1;
        end
        if (stb.txShift) txSh <= {txSh[6:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spiMemSlave.sv
module spiMemSlave
  import spiMemPkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sck,
  input  logic csN,
  input  logic si,
  output logic so,
  output logic soOe
);

  logic [2:0]        syncOut;
  strobe_t           stb;
  logic [7:0]        rxByte;
  ctrlState_t        ctrlState;
  logic [2:0]        bitCnt;
  logic [ADDR_W-1:0] addrQ;
  logic              welQ;
  logic              commitSeen;

  spiMemSync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .dIn ({sck, csN, si}),
    .dOut(syncOut)
  );

  spiMemCtrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sckS  (syncOut[2]),
    .csS   (syncOut[1]),
    .siS   (syncOut[0]),
    .stb   (stb),
    .rxByte(rxByte),
    .stateQ(ctrlState),
    .bitCnt(bitCnt)
  );

  spiMemData #(.ADDR_W(ADDR_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rxByte    (rxByte),
    .so        (so),
    .soOe      (soOe),
    .addrQ     (addrQ),
    .welQ      (welQ),
    .commitSeen(commitSeen)
  );

endmodule

// File: rtl/spiMemChecker.sv
module spiMemChecker
  import spiMemPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input strobe_t           stb,
  input ctrlState_t        ctrlState,
  input logic [2:0]        bitCnt,
  input logic [ADDR_W-1:0] addrQ,
  input logic              welQ,
  input logic              commitSeen,
  input logic              soOe
);

  assert_lock_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_LOCK) |-> !soOe);

  assert_oe_in_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    soOe |-> ((ctrlState == ST_RDAT) || (ctrlState == ST_RSTAT)));

  assert_commit_needs_wel_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(commitSeen) |-> $past(welQ));

  assert_addr_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.txLoadMem || stb.memWr) && (addrQ == '1)) |=> (addrQ == '0));

  assert_wel_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.setWel |=> welQ);

  assert_wel_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.csEnd && commitSeen) |=> !welQ);

  assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.csStart |=> ((ctrlState == ST_OPC) && (bitCnt == 3'd0)));

endmodule

bind spiMemSlave spiMemChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .stb       (stb),
  .ctrlState (ctrlState),
  .bitCnt    (bitCnt),
  .addrQ     (addrQ),
  .welQ      (welQ),
  .commitSeen(commitSeen),
  .soOe      (soOe)
);

// File: tb/spiMemSlave_bench.sv
module spiMemSlave_bench;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0;
  logic csN = 1'b1;
  logic si = 1'b0;
  logic so, soOe;

  int total = 0;
  int bad = 0;
  bit doneF = 1'b0;
  bit oeAny;

  logic [7:0] expQ[$];
  string      reqQ[$];
  logic [7:0] rxLast;
  logic       oeLast;
  event       rxEvt;

  always #4 clk = ~clk;

  spiMemSlave u_spiMemSlave (
    .clk (clk),
    .rstN(rstN),
    .sck (sck),
    .csN (csN),
    .si  (si),
    .so  (so),
    .soOe(soOe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic r, output logic oe);
    si = b;
    repeat (HALF) @(negedge clk);
    r  = so;
    oe = soOe;
    if (oe) oeAny = 1'b1;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    if (oe) chk(so === r, "R11 so stable while sck high", so, r);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, input int n, output logic [7:0] rx, output logic allOe);
    logic r, oe;
    rx = '0;
    allOe = 1'b1;
    for (int i = 0; i < n; i++) begin
      bitx(tx[7-i], r, oe);
      rx[7-i] = r;
      allOe = allOe & oe;
    end
  endtask

  task automatic csDown();
    @(negedge clk);
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csUp();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] d;
    logic oe;
    xfer(b, 8, d, oe);
  endtask

  task automatic expectByte(input logic [7:0] v, input string req);
    expQ.push_back(v);
    reqQ.push_back(req);
  endtask

  task automatic capture(input int n);
    logic [7:0] d;
    logic oe;
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, 8, d, oe);
      rxLast = d;
      oeLast = oe;
      ->rxEvt;
      @(negedge clk);
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    csDown(); send(op); csUp();
  endtask

  task automatic memWrite(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1, input int n);
    csDown();
    send(8'h02); send(a[15:8]); send(a[7:0]);
    oeAny = 1'b0;
    send(d0);
    if (n > 1) send(d1);
    chk(!oeAny, "R10 no output enable during write", oeAny, 0);
    csUp();
  endtask

  task automatic memRead(input logic [15:0] a, input int n);
    csDown();
    oeAny = 1'b0;
    send(8'h03); send(a[15:8]); send(a[7:0]);
    chk(!oeAny, "R10 no output enable during command/address", oeAny, 0);
    capture(n);
    csUp();
  endtask

  task automatic statRead(input int n);
    csDown(); send(8'h05); capture(n); csUp();
  endtask

  task automatic statWrite(input logic [7:0] v);
    csDown(); send(8'h01); send(v); csUp();
  endtask

  initial begin : monitor
    forever begin
      @(rxEvt);
      if (expQ.size() == 0) begin
        chk(1'b0, "scoreboard unexpected byte", rxLast, 0);
      end else begin
        logic [7:0] e;
        string rq;
        e  = expQ.pop_front();
        rq = reqQ.pop_front();
        chk(oeLast === 1'b1, {rq, " output enable"}, oeLast, 1);
        chk(rxLast === e, rq, rxLast, e);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!doneF) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    logic [7:0] d;
    logic oe;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(soOe === 1'b0, "R10 output enable low after reset", soOe, 0);

    expectByte(8'h00, "R8 status after reset");
    statRead(1);

    // R2 R7 set latch, R8 repeated status bytes
    cmd1(8'h06);
    expectByte(8'h02, "R7 latch visible as bit 1");
    expectByte(8'h02, "R8 repeated status byte");
    statRead(2);

    // R1 R5 burst write and read back; latch drops after write (R7)
    csDown(); send(8'h02); send(8'h00); send(8'h10);
    send(8'h81); send(8'h22); send(8'h3C); csUp();
    expectByte(8'h00, "R7 latch cleared after write");
    statRead(1);
    expectByte(8'h81, "R1 msb first data");
    expectByte(8'h22, "R5 increment");
    expectByte(8'h3C, "R5 increment");
    memRead(16'h0010, 3);

    // R6 write without latch ignored
    memWrite(16'h0010, 8'hFF, 8'h00, 1);
    expectByte(8'h81, "R6 write without latch ignored");
    memRead(16'h0010, 1);

    // R4 upper address bits ignored
    cmd1(8'h06);
    memWrite(16'hF812, 8'h44, 8'h00, 1);
    expectByte(8'h44, "R4 upper address bits ignored");
    memRead(16'h0012, 1);
    expectByte(8'h44, "R4 alias read");
    memRead(16'h0812, 1);

    // R5 wrap
    cmd1(8'h06);
    memWrite(16'h07FF, 8'h5A, 8'h6B, 2);
    expectByte(8'h5A, "R5 last location");
    expectByte(8'h6B, "R5 wrap to zero");
    memRead(16'h07FF, 2);

    // R7 disable
    cmd1(8'h06);
    cmd1(8'h04);
    expectByte(8'h00, "R7 latch cleared by disable");
    statRead(1);

    // R8 status write
    cmd1(8'h06);
    statWrite(8'hFF);
    expectByte(8'hFC, "R8 status write bits");
    statRead(1);
    statWrite(8'h00);
    expectByte(8'hFC, "R6 status write without latch ignored");
    statRead(1);
    cmd1(8'h06);
    statWrite(8'h00);

    // R3 lockout
    csDown();
    oeAny = 1'b0;
    send(8'hAB); send(8'h03); send(8'h00); send(8'h10); send(8'h00);
    chk(!oeAny, "R3 lockout keeps output disabled", oeAny, 0);
    send(8'h06);
    csUp();
    expectByte(8'h00, "R3 ignored bytes after bad opcode");
    statRead(1);
    expectByte(8'h81, "R12 normal read after lockout");
    memRead(16'h0010, 1);

    // R9 partial byte
    cmd1(8'h06);
    memWrite(16'h0020, 8'h00, 8'h00, 2);
    cmd1(8'h06);
    csDown(); send(8'h02); send(8'h00); send(8'h20); send(8'h77);
    xfer(8'hFF, 5, d, oe);
    csUp();
    expectByte(8'h77, "R9 full byte kept");
    expectByte(8'h00, "R9 partial byte discarded");
    memRead(16'h0020, 2);

    // R9 R7 select rise together with eighth clock rise
    cmd1(8'h06);
    memWrite(16'h0030, 8'h11, 8'h00, 1);
    cmd1(8'h06);
    csDown(); send(8'h02); send(8'h00); send(8'h30);
    xfer(8'hEE, 7, d, oe);
    si = 1'b0;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    csN = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
    repeat (3 * HALF) @(negedge clk);
    expectByte(8'h11, "R9 coincident edge byte discarded");
    memRead(16'h0030, 1);
    expectByte(8'h02, "R7 latch kept with no accepted byte");
    statRead(1);

    // R12 abort mid address
    csDown(); send(8'h03); xfer(8'h00, 4, d, oe); csUp();
    chk(soOe === 1'b0, "R12 output disabled after abort", soOe, 0);
    expectByte(8'h02, "R12 fresh command after abort");
    statRead(1);

    repeat (20) @(negedge clk);
    chk(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    doneF = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule